// File: doc/BRIEF.md
# Stepped Attenuator Gain-Code Controller

This block keeps the six-bit attenuation code for one channel of a digitally stepped gain amplifier. Code 0 selects the highest gain and each increment adds 0.5 dB of attenuation, so code 63 is the lowest gain and the full range is 31.5 dB. Bit k of the code weighs 0.5 dB times 2^k.

The code can change in two ways. In parallel mode, a six-bit data bus is copied into the code register on every clock while the hold input is low. The register keeps its value while hold is high. In pulse mode, rising edges on an increase-gain input or a decrease-gain input move the code by a selectable step, and the result saturates at the ends of the range. Rising both inputs together returns the channel to maximum gain. A channel enable input is registered and presented beside the code.

Top module: `gain_code_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the gain code to 0 (maximum gain) and the enable flag to 0.
- R2: When the mode select is 2'b11 (parallel mode) and hold is 0, the code after the next clock edge equals the parallel data bus.
- R3: When the mode select is 2'b11 and hold is 1, the code does not change, whatever the data bus does.
- R4: When the mode select equals the pulse-mode value (parameter, default 2'b01), a rising edge on the gain-up input lowers the code by one step, with the change visible after that clock edge. An input held high for many cycles gives exactly one step.
- R5: In pulse mode, a rising edge on the gain-down input raises the code by one step.
- R6: The step-size select maps to a code distance as follows: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 12 (0.5, 1, 2 and 6 dB).
- R7: Pulse steps saturate. An up step larger than the code gives 0, and a down step past 63 gives 63.
- R8: In pulse mode, if a rising edge occurs on either pulse input while both pulse inputs are high, the code becomes 0.
- R9: With any mode select value other than 2'b11 and the pulse-mode value, the code keeps its value regardless of data, hold and pulse inputs.
- R10: The enable flag equals the channel enable input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 2'b11 parallel, PULSE_MODE pulse, anything else freeze |
| hold | input | 1 | Parallel-mode hold: 0 follows the bus, 1 keeps the code |
| gain_up | input | 1 | Pulse input that raises gain (lowers the code) |
| gain_dn | input | 1 | Pulse input that lowers gain (raises the code) |
| step_sel | input | 2 | Pulse step size select |
| par_code | input | 6 | Parallel code bus |
| chan_en | input | 1 | Channel enable, active high |
| gain_code | output | 6 | Registered attenuation code |
| en_out | output | 1 | Registered enable flag |

## Verification
The hardest cases to reach are the saturation boundaries for every step size, because each one needs an exact starting code on the pulse path. The stimulus uses the parallel path as a loader. Each start code from 0 to 63 is written in parallel mode. The mode is then switched to pulse mode in the same cycle that a single pulse edge arrives. This sweeps all 512 combinations of start code, step size and direction against expected values computed in the bench. Separate sequences keep a pulse high for several cycles, and raise the second pulse input while the first is already high.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam logic [1:0] MODE_PAR = 2'b11;

  // code distance for each step-size select value
  function automatic int unsigned step_lsbs(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/gcc_rise_det.sv
module gcc_rise_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= din;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = din[i] & ~prev[i];
  end
endmodule

// File: rtl/gcc_step_sat.sv
module gcc_step_sat #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_in,
  input  logic [1:0]        step_sel,
  input  logic              toward_zero,
  output logic [CODE_W-1:0] code_out
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] CODE_MAX = SUM_W'((1 << CODE_W) - 1);

  logic [SUM_W-1:0] step_w;
  logic [SUM_W-1:0] wide_in;
  logic [SUM_W-1:0] sum;

  assign step_w  = SUM_W'(gcc_pkg::step_lsbs(step_sel));
  assign wide_in = {1'b0, code_in};
  assign sum     = wide_in + step_w;

  always_comb begin
    if (toward_zero) begin
      if (wide_in < step_w) code_out = '0;
      else                  code_out = CODE_W'(wide_in - step_w);
    end else begin
      if (sum > CODE_MAX)   code_out = CODE_MAX[CODE_W-1:0];
      else                  code_out = sum[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/gain_code_ctrl.sv
module gain_code_ctrl #(
  parameter int         CODE_W     = 6,
  parameter logic [1:0] PULSE_MODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              hold,
  input  logic              gain_up,
  input  logic              gain_dn,
  input  logic [1:0]        step_sel,
  input  logic [CODE_W-1:0] par_code,
  input  logic              chan_en,
  output logic [CODE_W-1:0] gain_code,
  output logic              en_out
);
  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'((1 << CODE_W) - 1);

  logic [1:0]        rise;
  logic              up_rise, dn_rise, any_rise, both_hi;
  logic              par_mode, pulse_mode;
  logic [CODE_W-1:0] stepped;
  logic [CODE_W-1:0] code_nxt;

  gcc_rise_det #(.W(2)) u_rise (
    .clk  (clk),
    .rst  (rst),
    .din  ({gain_dn, gain_up}),
    .rise (rise)
  );

  assign up_rise    = rise[0];
  assign dn_rise    = rise[1];
  assign any_rise   = up_rise | dn_rise;
  assign both_hi    = gain_up & gain_dn;
  assign par_mode   = (mode_sel == gcc_pkg::MODE_PAR);
  assign pulse_mode = (mode_sel == PULSE_MODE);

  gcc_step_sat #(.CODE_W(CODE_W)) u_step (
    .code_in     (gain_code),
    .step_sel    (step_sel),
    .toward_zero (up_rise),
    .code_out    (stepped)
  );

  always_comb begin
    code_nxt = gain_code;
    if (par_mode) begin
      if (!hold) code_nxt = par_code;
    end else if (pulse_mode && any_rise) begin
      if (both_hi) code_nxt = '0;
      else         code_nxt = stepped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_code <= '0;
      en_out    <= 1'b0;
    end else begin
      gain_code <= code_nxt;
      en_out    <= chan_en;
    end
  end

  assert_par_load_R2: assert property (@(posedge clk) disable iff (rst)
    (par_mode && !hold) |=> (gain_code == $past(par_code)));

  assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (par_mode && hold) |=> $stable(gain_code));

  assert_up_not_rising_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && up_rise && !gain_dn) |=> (gain_code <= $past(gain_code)));

  assert_dn_not_falling_R5: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && dn_rise && !gain_up) |=> (gain_code >= $past(gain_code)));

  assert_top_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && dn_rise && !gain_up && gain_code == CODE_TOP) |=> (gain_code == CODE_TOP));

  assert_both_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && any_rise && both_hi) |=> (gain_code == '0));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && !pulse_mode) |=> $stable(gain_code));

  assert_en_follow_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (en_out == $past(chan_en)));
endmodule

// File: tb/gain_code_ctrl_bench.sv
`timescale 1ns/1ps
module gain_code_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic       hold, gain_up, gain_dn, chan_en;
  logic [1:0] step_sel;
  logic [5:0] par_code;
  logic [5:0] gain_code;
  logic       en_out;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  gain_code_ctrl u_gain_code_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .hold(hold),
    .gain_up(gain_up), .gain_dn(gain_dn), .step_sel(step_sel),
    .par_code(par_code), .chan_en(chan_en),
    .gain_code(gain_code), .en_out(en_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step_of(input int sel);
    return (sel == 3) ? 12 : (1 << sel);
  endfunction

  task automatic load(input int c);
    mode_sel = 2'b11; hold = 1'b0; par_code = 6'(c);
    tick();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_sel = 2'b11; hold = 1'b0; gain_up = 1'b0; gain_dn = 1'b0;
    step_sel = 2'b00; par_code = 6'd45; chan_en = 1'b1;
    tick(); tick();
    check("R1 code", int'(gain_code), 0);
    check("R1 en", int'(en_out), 0);
    rst = 1'b0;

    // R10 enable follows with one cycle delay
    chan_en = 1'b0; tick(); check("R10", int'(en_out), 0);
    chan_en = 1'b1; tick(); check("R10", int'(en_out), 1);

    // R2 parallel load sweep
    for (int c = 0; c < 64; c++) begin
      load(c);
      check("R2", int'(gain_code), c);
    end

    // R3 hold freezes
    load(21);
    hold = 1'b1;
    for (int c = 0; c < 64; c += 7) begin
      par_code = 6'(c); tick();
      check("R3", int'(gain_code), 21);
    end

    // R4 R5 R6 R7 exhaustive single-step sweep
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 64; c++) begin
        for (int d = 0; d < 2; d++) begin
          int e;
          load(c);
          mode_sel = 2'b01; step_sel = 2'(s);
          if (d == 0) gain_up = 1'b1; else gain_dn = 1'b1;
          tick();
          if (d == 0) e = (c < step_of(s)) ? 0 : c - step_of(s);
          else        e = (c + step_of(s) > 63) ? 63 : c + step_of(s);
          check(d == 0 ? "R4 R6 R7 up" : "R5 R6 R7 dn", int'(gain_code), e);
          gain_up = 1'b0; gain_dn = 1'b0;
          tick();
        end
      end
    end

    // R4 long pulse gives one step only
    load(40);
    mode_sel = 2'b01; step_sel = 2'b10; gain_up = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R4 long pulse", int'(gain_code), 36);
    end
    gain_up = 1'b0; tick();
    gain_dn = 1'b1; tick(); check("R5 after long", int'(gain_code), 40);
    gain_dn = 1'b0; tick();

    // R8 simultaneous rise
    load(50);
    mode_sel = 2'b01; gain_up = 1'b1; gain_dn = 1'b1; tick();
    check("R8 together", int'(gain_code), 0);
    gain_up = 1'b0; gain_dn = 1'b0; tick();
    // R8 second input rises while first held
    load(30);
    mode_sel = 2'b01; step_sel = 2'b00; gain_dn = 1'b1; tick();
    check("R5 pre", int'(gain_code), 31);
    gain_up = 1'b1; tick();
    check("R8 staggered", int'(gain_code), 0);
    gain_up = 1'b0; gain_dn = 1'b0; tick();

    // R9 other modes freeze
    for (int m = 0; m < 2; m++) begin
      load(17);
      mode_sel = (m == 0) ? 2'b00 : 2'b10;
      hold = 1'b0; par_code = 6'd60; gain_up = 1'b1; tick();
      check("R9", int'(gain_code), 17);
      gain_up = 1'b0; gain_dn = 1'b1; tick();
      check("R9", int'(gain_code), 17);
      gain_dn = 1'b0; tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule